// File: doc/BRIEF.md
# TDM Serial Transmit Channel Multiplexer

This block is the transmit side of a time-division-multiplexed serial port. It runs on the serial bit clock. A frame sync pulse starts a frame, and the block then drives one bit per clock, least significant bit first. It has two modes. In simple mode a single word from channel 0 is shifted out after each sync. In frame mode up to sixteen logical channels each place a sample into their own window of the frame. Each channel's window is set by a start position and a sample-length code.

Software programs the block through a small write port. Each write selects a register kind (sample data, start position, length code or control) and a channel number. Three interrupt outputs report events. The buffer-empty interrupt tells software when to refill the sample registers, and in frame mode it can be paced to every 2, 4, 8 or 16 frames. The frame-error interrupt flags a sync that arrives before the frame is complete. The collision interrupt flags another agent overdriving the line when the output is used as open-drain.

Top module: `tdm_tx_mux`

## Requirements
- R1: After reset, sdo_o is 1, sdo_oe_o is 0 and all three interrupts are 0.
- R2: In frame mode, if a frame sync is sampled at clock edge E, bit k of the frame is visible on sdo_o after edge E+k. An enabled channel with start s and length L drives its sample bits 0..L-1 on frame bits s..s+L-1. The length codes are 00=16, 01=8, 10=4 and 11=2 bits. Writes use wr_sel_i 0=data, 1=start, 2=length, 3=control. The start write carries the position in wr_data_i[7:0] and the enable in wr_data_i[15].
- R3: sdo_o is 1 outside every enabled channel window and while no frame is active. Disabled channels have no effect on the output.
- R4: Several channels in adjacent, non-overlapping windows appear in the same frame, each at its own positions.
- R5: In simple mode (control bit 0), channel 0's sample is driven on frame bits 0..L-1, with L taken from channel 0's length code. Channel 0's start position and all other channels are ignored. sdo_o is 1 afterwards.
- R6: In simple mode, be_irq_o rises at the edge after the one at which bit 0 is driven. It is cleared by any sample-data write or by an output reset (control bit 8).
- R7: In frame mode, an output reset written together with continuous mode (control bit 5) makes be_irq_o rise on the first frame. While bit 5 stays set, it rises again every N frames, with N = 2, 4, 8 or 16 for rate code 00..11 in control bits 4:3. Without bit 5, it never rises.
- R8: In frame mode, a sync sampled while a frame is active and before its last bit is due sets fe_irq_o. A sync exactly at the last bit does not. The frame length code in control bits 2:1 selects 64·(code+1) bits. Only the output reset clears fe_irq_o.
- R9: With open-drain mode (control bit 6) and output enable (control bit 7) set in frame mode, a pin readback that differs from the driven bit inside an enabled window sets col_irq_o. The output reset or the collision reset (control bit 9) clears it.
- R10: When output enable is set, sdo_oe_o is 1 in push-pull mode. In open-drain mode, sdo_oe_o is 1 only while the driven bit is 0.
- R11: In simple mode, fe_irq_o and col_irq_o never rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register kind: 0 data, 1 start, 2 length, 3 control |
| wr_ch_i | input | 4 | Channel number of the write |
| wr_data_i | input | 16 | Write data |
| sdo_pin_i | input | 1 | Readback of the serial line |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable |
| be_irq_o | output | 1 | Buffer-empty interrupt |
| fe_irq_o | output | 1 | Frame-error interrupt |
| col_irq_o | output | 1 | Collision interrupt |

## Verification
Frame bit k is due on sdo_o after the k-th clock edge that follows the edge at which the sync is sampled. The bench raises the sync at a falling edge and reads bit 0 at the next falling edge, then one bit per falling edge after that. The output enable follows the driven bit in the same cycle. Buffer-empty is due one edge after bit 0. Frame-error and collision are due at the edge that samples the early sync or the mismatching readback. Every register write and control clear takes effect at the rising edge inside the write task, so each check is placed at the falling edge that follows the edge that must cause the change.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic       oe;
    logic       od;
    logic       cont;
    logic [1:0] rate;
    logic [1:0] flen;
    logic       simple;
  } ctrl_t;

  localparam int CTRL_ORST = 8;
  localparam int CTRL_CRST = 9;

  function automatic logic [4:0] len_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd16;
      2'b01:   return 5'd8;
      2'b10:   return 5'd4;
      default: return 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_chan_regs.sv
module tdm_tx_chan_regs #(
  parameter int NUM_CH = 16,
  parameter int POS_W  = 8,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [1:0]                        wr_sel_i,
  input  logic [CH_W-1:0]                   wr_ch_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_CH-1:0]                 en_o,
  output logic [NUM_CH-1:0][POS_W-1:0]      start_o,
  output logic [NUM_CH-1:0][1:0]            len_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]     data_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]    <= 1'b0;
        start_o[g] <= '0;
        len_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (sel) begin
        case (wr_sel_i)
          2'd0: data_o[g] <= wr_data_i;
          2'd1: begin
            start_o[g] <= wr_data_i[POS_W-1:0];
            en_o[g]    <= wr_data_i[DATA_W-1];
          end
          2'd2: len_o[g] <= wr_data_i[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdm_tx_slot_sel.sv
module tdm_tx_slot_sel #(
  parameter int NUM_CH = 16,
  parameter int POS_W  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]                  pos_i,
  input  logic [NUM_CH-1:0]                 en_i,
  input  logic [NUM_CH-1:0][POS_W-1:0]      start_i,
  input  logic [NUM_CH-1:0][1:0]            len_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]     data_i,
  output logic                              hit_o,
  output logic                              bit_o
);
  logic [NUM_CH-1:0] hit, bits;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    logic [POS_W:0] lo, hi, pos, off;
    assign lo      = {1'b0, start_i[g]};
    assign hi      = lo + (POS_W+1)'(tdm_tx_pkg::len_bits(len_i[g]));
    assign pos     = {1'b0, pos_i};
    assign off     = pos - lo;
    assign hit[g]  = en_i[g] && (pos >= lo) && (pos < hi);
    assign bits[g] = data_i[g][off[IDX_W-1:0]];
  end

  assign hit_o = |hit;
  assign bit_o = |(hit & bits);
endmodule

// File: rtl/tdm_tx_irq.sv
module tdm_tx_irq #(
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       simple_i,
  input  logic       cont_i,
  input  logic [1:0] rate_i,
  input  logic       od_i,
  input  logic       oe_i,
  input  logic       out_rst_i,
  input  logic       arm_i,
  input  logic       col_rst_i,
  input  logic       data_wr_i,
  input  logic       first_bit_i,
  input  logic       early_sync_i,
  input  logic       mismatch_i,
  output logic       be_o,
  output logic       fe_o,
  output logic       col_o
);
  logic             pend_q;
  logic [CNT_W-1:0] fcnt_q;
  logic [CNT_W-1:0] fcnt_last;

  assign fcnt_last = CNT_W'((5'd2 << rate_i) - 5'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_o   <= 1'b0;
      pend_q <= 1'b0;
      fcnt_q <= '0;
    end else if (out_rst_i) begin
      be_o   <= 1'b0;
      pend_q <= arm_i;
      fcnt_q <= '0;
    end else if (first_bit_i && simple_i) begin
      be_o <= 1'b1;
    end else if (first_bit_i && pend_q) begin
      be_o   <= 1'b1;
      pend_q <= 1'b0;
      fcnt_q <= '0;
    end else if (first_bit_i && cont_i) begin
      if (fcnt_q == fcnt_last) begin
        be_o   <= 1'b1;
        fcnt_q <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
        if (data_wr_i) be_o <= 1'b0;
      end
    end else if (data_wr_i) begin
      be_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           fe_o <= 1'b0;
    else if (out_rst_i)                    fe_o <= 1'b0;
    else if (early_sync_i && !simple_i)    fe_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         col_o <= 1'b0;
    else if (out_rst_i || col_rst_i)                     col_o <= 1'b0;
    else if (mismatch_i && !simple_i && od_i && oe_i)    col_o <= 1'b1;
  end

  // R8
  fe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_o) |-> $past(early_sync_i));
  // R9
  col_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_o) |-> $past(od_i && oe_i && mismatch_i));
  // R11
  simple_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(simple_i) |-> !$rose(fe_o) && !$rose(col_o));
  // R6
  out_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_rst_i) |-> !be_o && !fe_o && !col_o);
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux #(
  parameter int NUM_CH = 16,
  parameter int POS_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int DATA_W = tdm_tx_pkg::DATA_W,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sdo_pin_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              be_irq_o,
  output logic              fe_irq_o,
  output logic              col_irq_o
);
  import tdm_tx_pkg::*;

  ctrl_t                         ctrl_q;
  logic                          active_q;
  logic [POS_W-1:0]              pos_q, last_pos;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0][POS_W-1:0]  ch_start;
  logic [NUM_CH-1:0][1:0]        ch_len;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_data;
  logic                          win_hit, win_bit, simple_hit, tx_bit, in_win;
  logic                          ctrl_wr, out_rst, col_rst, data_wr, early_sync;

  assign ctrl_wr = wr_en_i && (wr_sel_i == 2'd3);
  assign out_rst = ctrl_wr && wr_data_i[CTRL_ORST];
  assign col_rst = ctrl_wr && wr_data_i[CTRL_CRST];
  assign data_wr = wr_en_i && (wr_sel_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[7:0]);
  end

  tdm_tx_chan_regs #(.NUM_CH(NUM_CH), .POS_W(POS_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_ch_i, .wr_data_i,
    .en_o(ch_en), .start_o(ch_start), .len_o(ch_len), .data_o(ch_data)
  );

  tdm_tx_slot_sel #(.NUM_CH(NUM_CH), .POS_W(POS_W), .DATA_W(DATA_W)) u_sel (
    .pos_i(pos_q), .en_i(ch_en), .start_i(ch_start), .len_i(ch_len),
    .data_i(ch_data), .hit_o(win_hit), .bit_o(win_bit)
  );

  // last bit position of the current frame
  always_comb begin
    if (ctrl_q.simple) last_pos = POS_W'(len_bits(ch_len[0])) - 1'b1;
    else               last_pos = POS_W'({ctrl_q.flen, 6'h3f});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (out_rst) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (fsync_i) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (active_q) begin
      if (pos_q == last_pos) active_q <= 1'b0;
      else                   pos_q    <= pos_q + 1'b1;
    end
  end

  assign early_sync = fsync_i && active_q && (pos_q != last_pos);
  assign simple_hit = pos_q < POS_W'(len_bits(ch_len[0]));
  assign in_win     = active_q && (ctrl_q.simple ? simple_hit : win_hit);

  always_comb begin
    if (!in_win)            tx_bit = 1'b1;
    else if (ctrl_q.simple) tx_bit = ch_data[0][pos_q[IDX_W-1:0]];
    else                    tx_bit = win_bit;
  end

  assign sdo_o    = tx_bit;
  assign sdo_oe_o = ctrl_q.oe && (!ctrl_q.od || !tx_bit);

  tdm_tx_irq u_irq (
    .clk_i, .rst_ni,
    .simple_i(ctrl_q.simple), .cont_i(ctrl_q.cont), .rate_i(ctrl_q.rate),
    .od_i(ctrl_q.od), .oe_i(ctrl_q.oe),
    .out_rst_i(out_rst), .arm_i(wr_data_i[5]), .col_rst_i(col_rst),
    .data_wr_i(data_wr), .first_bit_i(active_q && (pos_q == '0)),
    .early_sync_i(early_sync), .mismatch_i(in_win && (sdo_pin_i != tx_bit)),
    .be_o(be_irq_o), .fe_o(fe_irq_o), .col_o(col_irq_o)
  );

  // R3
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> sdo_o);
  // R10
  od_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.od && sdo_oe_o) |-> !sdo_o);
  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.oe |-> !sdo_oe_o);
endmodule

// File: tb/tdm_tx_mux_tb.sv
module tdm_tx_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIMPLE = 1, FLEN1 = 2, RATE1 = 8, CONT = 32, OD = 64, OE = 128;
  localparam int ORST = 256, CRST = 512;

  typedef struct packed {
    logic [15:0] d;
    logic [7:0]  s;
    logic [1:0]  l;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'hA53C, 8'd0,  2'b00},
    '{16'h00F0, 8'd10, 2'b01},
    '{16'h0009, 8'd60, 2'b10},
    '{16'h0002, 8'd62, 2'b11},
    '{16'h1234, 8'd48, 2'b00},
    '{16'h0081, 8'd30, 2'b01}
  };

  logic clk = 0, rst_n = 0, fsync = 0, wr_en = 0, other_drv = 1;
  logic [1:0]  wr_sel = 0;
  logic [3:0]  wr_ch = 0;
  logic [15:0] wr_data = 0;
  logic sdo, sdo_oe, be_irq, fe_irq, col_irq, pin;
  int n_chk = 0, n_err = 0;
  logic [63:0] bits, oes, expv;

  assign pin = (sdo_oe ? sdo : 1'b1) & other_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_tx_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_ch_i(wr_ch), .wr_data_i(wr_data), .sdo_pin_i(pin),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .be_irq_o(be_irq), .fe_irq_o(fe_irq),
    .col_irq_o(col_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] ch, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_ch = ch; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ctrl(input int v);
    wr(2'd3, 4'd0, 16'(v));
  endtask

  task automatic pulse_sync();
    fsync = 1;
    @(negedge clk);
    fsync = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_frame(output logic [63:0] b, output logic [63:0] o);
    pulse_sync();
    for (int k = 0; k < 64; k++) begin
      b[k] = sdo; o[k] = sdo_oe;
      @(negedge clk);
    end
  endtask

  function automatic int lbits(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 8;
      2'b10: return 4;
      default: return 2;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait_n(3);
    // R1 reset state
    chk("R1 reset outputs", {59'd0, sdo, sdo_oe, be_irq, fe_irq, col_irq}, 64'b10000);
    rst_n = 1;
    wait_n(2);
    ctrl(OE | ORST);

    // R2 table of single-channel placements
    for (int v = 0; v < 6; v++) begin
      wr(2'd1, 4'd0, {1'b1, 7'd0, VEC[v].s});
      wr(2'd2, 4'd0, {14'd0, VEC[v].l});
      wr(2'd0, 4'd0, VEC[v].d);
      run_frame(bits, oes);
      expv = '1;
      for (int j = 0; j < lbits(VEC[v].l); j++) expv[VEC[v].s + j] = VEC[v].d[j];
      chk($sformatf("R2 vector %0d", v), bits, expv);
    end
    chk("R10 push-pull oe high", oes, '1);
    wr(2'd1, 4'd0, 16'd0);

    // R4 adjacent channels, R3 disabled overlapping channel
    wr(2'd1, 4'd3, 16'h8014); wr(2'd2, 4'd3, 16'd2); wr(2'd0, 4'd3, 16'h0005);
    wr(2'd1, 4'd7, 16'h8018); wr(2'd2, 4'd7, 16'd1); wr(2'd0, 4'd7, 16'h00C3);
    wr(2'd1, 4'd9, 16'h0000); wr(2'd2, 4'd9, 16'd0); wr(2'd0, 4'd9, 16'h0000);
    run_frame(bits, oes);
    expv = '1;
    expv[23:20] = 4'h5;
    expv[31:24] = 8'hC3;
    chk("R4 two adjacent channels", bits, expv);
    wr(2'd1, 4'd3, 16'h0014); wr(2'd1, 4'd7, 16'h0018);
    run_frame(bits, oes);
    chk("R3 all disabled line high", bits, '1);

    // R8 sync exactly at the last bit, then an early sync
    pulse_sync();
    wait_n(63);
    pulse_sync();
    chk("R8 sync at frame end no error", 64'(fe_irq), 0);
    wait_n(10);
    pulse_sync();
    chk("R8 early sync error", 64'(fe_irq), 1);
    ctrl(OE | CRST);
    chk("R8 collision reset keeps error", 64'(fe_irq), 1);
    ctrl(OE | ORST);
    chk("R8 output reset clears error", 64'(fe_irq), 0);
    ctrl(OE | FLEN1 | ORST);
    pulse_sync();
    wait_n(63);
    pulse_sync();
    chk("R8 128-bit frame sync at 64 is early", 64'(fe_irq), 1);

    // R7 frame pacing, rate code 01 = every 4 frames
    ctrl(OE | RATE1 | CONT | ORST);
    run_frame(bits, oes);
    chk("R7 first frame after init", 64'(be_irq), 1);
    wr(2'd0, 4'd5, 16'h1111);
    chk("R7 cleared by data write", 64'(be_irq), 0);
    for (int f = 2; f <= 4; f++) begin
      run_frame(bits, oes);
      chk($sformatf("R7 no request at frame %0d", f), 64'(be_irq), 0);
    end
    run_frame(bits, oes);
    chk("R7 request at frame 5", 64'(be_irq), 1);
    ctrl(OE | ORST);
    run_frame(bits, oes);
    chk("R7 no request without continuous mode", 64'(be_irq), 0);

    // R5 simple mode word, R6 buffer-empty timing
    ctrl(OE | SIMPLE | ORST);
    wr(2'd1, 4'd0, 16'h8028); wr(2'd2, 4'd0, 16'd1); wr(2'd0, 4'd0, 16'h00A5);
    wr(2'd1, 4'd1, 16'h8000); wr(2'd2, 4'd1, 16'd0); wr(2'd0, 4'd1, 16'h0000);
    run_frame(bits, oes);
    expv = '1;
    expv[7:0] = 8'hA5;
    chk("R5 simple word only", bits, expv);
    chk("R6 simple request set", 64'(be_irq), 1);
    wr(2'd0, 4'd2, 16'h0000);
    chk("R6 data write clears", 64'(be_irq), 0);
    pulse_sync();
    chk("R6 not yet at bit 0", 64'(be_irq), 0);
    @(negedge clk);
    chk("R6 set after bit 0", 64'(be_irq), 1);
    wait_n(10);
    ctrl(OE | SIMPLE | ORST);
    chk("R6 output reset clears", 64'(be_irq), 0);

    // R11 simple mode ignores collisions and early syncs
    ctrl(OE | OD | SIMPLE | ORST);
    pulse_sync();
    other_drv = 0;
    wait_n(3);
    other_drv = 1;
    pulse_sync();
    wait_n(10);
    chk("R11 no error or collision", {62'd0, fe_irq, col_irq}, 0);

    // R9 / R10 open-drain collision
    ctrl(OE | OD | ORST);
    wr(2'd1, 4'd1, 16'h0000);
    wr(2'd1, 4'd0, 16'h8000); wr(2'd2, 4'd0, 16'd0); wr(2'd0, 4'd0, 16'hFFF0);
    pulse_sync();
    chk("R10 open-drain drives low", {62'd0, sdo, sdo_oe}, 2'b01);
    wait_n(4);
    chk("R10 open-drain releases high", {62'd0, sdo, sdo_oe}, 2'b10);
    other_drv = 0;
    @(negedge clk);
    other_drv = 1;
    chk("R9 collision detected", 64'(col_irq), 1);
    ctrl(OE | OD | CRST);
    chk("R9 collision reset clears", 64'(col_irq), 0);
    other_drv = 0;
    @(negedge clk);
    other_drv = 1;
    chk("R9 collision again", 64'(col_irq), 1);
    ctrl(OE | OD | ORST);
    chk("R9 output reset clears", 64'(col_irq), 0);
    pulse_sync();
    wait_n(20);
    other_drv = 0;
    @(negedge clk);
    other_drv = 1;
    chk("R9 outside window no collision", 64'(col_irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule